// File: doc/BRIEF.md
# Legacy INTx Message Request Controller

This block sits between software and a virtual-wire message generator. Software reaches one control register through an AXI4-Lite responder. Writing a command value to that register asks for an assert or a deassert message on one of the four legacy interrupt lines, INTA to INTD. The matching command bit stays set while the request is outstanding and clears itself once the generator acknowledges it. Software polls the register to learn when its request has been handled.

Requests are only produced when legacy interrupts are allowed. That means the interrupt-disable bit of the configuration Command register (bit 10 there) must be clear, and MSI must be switched off. The block also remembers whether the virtual wire is asserted. A command that would not change the wire level completes on the spot, and no message is sent for it. A four-signal request/acknowledge port stands in for the message generator.

Top module: `intx_msg_ctrl`

## Requirements
- R1: After reset `msg_valid` is 0, `intx_level` is 0 (deasserted), `s_bvalid` and `s_rvalid` are 0, and a read of the control register returns 0.
- R2: A full-strobe write of data 0x1 to the control register, made while enabled, idle and deasserted, sets `msg_valid` in the cycle after the write handshake. It presents `msg_assert`=1 and `msg_pin` equal to `cfg_intx_pin` as sampled at the write, and register bit 0 reads back as 1.
- R3: A full-strobe write of data 0x2, made while enabled, idle and asserted, raises a request with `msg_assert`=0, and register bit 1 reads back as 1.
- R4: While `msg_valid` is 1 and `msg_ack` is 0, `msg_valid`, `msg_assert` and `msg_pin` hold their values.
- R5: `msg_ack` sampled high while `msg_valid` is 1 clears the command bit and `msg_valid` on that edge. `intx_level` becomes 1 after an assert and 0 after a deassert, and the register then reads 0.
- R6: A command written while `cfg_intx_disable` or `cfg_msi_en` is 1 is dropped: no request is raised and the register stays 0.
- R7: At most one request is outstanding. Control-register writes that arrive while a command bit is set leave the request and the register unchanged.
- R8: Writes with data other than 0x1 or 0x2 (including 0x0 and 0x3), writes without all strobe bits set, and writes to any other address are dropped.
- R9: An assert written while `intx_level` is 1, or a deassert written while it is 0, completes at once: no request is raised and the register stays 0.
- R10: Every write returns `s_bresp`=00 (OKAY) with `s_bvalid` rising one cycle after the handshake and held until `s_bready`. Every read returns `s_rresp`=00 with `s_rvalid` one cycle after the handshake. The read data holds the command bits in [1:0] and zeros above; reads of other addresses return zero.
- R11: `msg_ack` while `msg_valid` is 0 has no effect on `intx_level` or the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| cfg_intx_disable | input | 1 | Interrupt-disable bit of the configuration Command register |
| cfg_msi_en | input | 1 | MSI enable from configuration space |
| cfg_intx_pin | input | 2 | Line select, 0=INTA to 3=INTD |
| msg_valid | output | 1 | Message request outstanding |
| msg_assert | output | 1 | 1 = assert message, 0 = deassert message |
| msg_pin | output | 2 | Line the message applies to |
| msg_ack | input | 1 | Completion pulse from the message generator |
| intx_level | output | 1 | Current virtual-wire level, 1 = asserted |

## Verification
A write takes effect on the edge of its handshake. `msg_valid`, the message fields and the write response are therefore due one cycle later, and the bench samples them on the following falling edge. An acknowledge clears the request and moves `intx_level` on the edge where it is sampled, so the outputs are checked on the falling edge right after the pulse. Read data reflects the command bits at the read handshake and appears with `s_rvalid` one cycle later. A reference model in the bench updates its pending command and wire level at the same edges, and every check compares against that model.

// File: rtl/intx_pkg.sv
// Package: shared types and constants for the legacy INTx request controller.
// Assumes: AXI4-Lite response encoding OKAY = 2'b00.
package intx_pkg;

    // Command field held in the control register, bits [1:0]
    typedef enum logic [1:0] {
        CMD_NONE     = 2'b00,
        CMD_ASSERT   = 2'b01,
        CMD_DEASSERT = 2'b10,
        CMD_BAD      = 2'b11
    } intx_cmd_e;

    localparam logic [1:0] RESP_OKAY = 2'b00;
    localparam int unsigned PIN_W    = 2;

endpackage

// File: rtl/intx_axil_port.sv
// Module: AXI4-Lite responder for the single control register.
// Accepts a write only when address and data are both valid and no response
// is pending; turns an accepted, full-strobe write to CTRL_OFFSET into a
// one-cycle command strobe for the engine. Reads return the command bits.
// Assumes: the engine samples wr_en/wr_code on the handshake edge.
module intx_axil_port
    import intx_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned DATA_W      = 32,
    parameter logic [ADDR_W-1:0] CTRL_OFFSET = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [DATA_W-1:0] s_wdata,
    input  logic [DATA_W/8-1:0] s_wstrb,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic [1:0]        s_bresp,
    output logic              s_bvalid,
    input  logic              s_bready,
    input  logic [ADDR_W-1:0] s_araddr,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [DATA_W-1:0] s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rvalid,
    input  logic              s_rready,
    input  logic [1:0]        cmd_bits,
    output logic              wr_en,
    output intx_cmd_e         wr_code
);

    localparam int unsigned STRB_W = DATA_W / 8;
    localparam logic [DATA_W-1:0] VAL_ASSERT   = DATA_W'(1);
    localparam logic [DATA_W-1:0] VAL_DEASSERT = DATA_W'(2);

    logic wr_hs;
    logic rd_hs;

    // Write channel: take address and data together when no response waits
    always_comb begin
        s_awready = s_awvalid & s_wvalid & ~s_bvalid;
        s_wready  = s_awready;
        wr_hs     = s_awready;
    end

    // Command decode: only an exact 0x1 or 0x2 with all strobes counts
    always_comb begin
        if (s_wdata == VAL_ASSERT)
            wr_code = CMD_ASSERT;
        else if (s_wdata == VAL_DEASSERT)
            wr_code = CMD_DEASSERT;
        else
            wr_code = CMD_NONE;
        wr_en = wr_hs && (s_awaddr == CTRL_OFFSET) && (s_wstrb == {STRB_W{1'b1}});
    end

    // Write response register: raise after handshake, drop on bready
    always_ff @(posedge clk) begin
        if (!rst_n)
            s_bvalid <= 1'b0;
        else if (wr_hs)
            s_bvalid <= 1'b1;
        else if (s_bready)
            s_bvalid <= 1'b0;
    end

    assign s_bresp = RESP_OKAY;

    // Read address ready whenever no read data is waiting
    always_comb begin
        s_arready = ~s_rvalid;
        rd_hs     = s_arvalid & s_arready;
    end

    // Read data register: capture command bits or zero on handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_rvalid <= 1'b0;
            s_rdata  <= '0;
        end else if (rd_hs) begin
            s_rvalid <= 1'b1;
            s_rdata  <= (s_araddr == CTRL_OFFSET) ? {{(DATA_W-2){1'b0}}, cmd_bits} : '0;
        end else if (s_rready) begin
            s_rvalid <= 1'b0;
        end
    end

    assign s_rresp = RESP_OKAY;

    // R10: write response always OKAY
    a_r10_bresp_okay: assert property (@(posedge clk) disable iff (!rst_n)
        s_bvalid |-> s_bresp == RESP_OKAY);

    // R10: write response held until accepted
    a_r10_bvalid_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (s_bvalid && !s_bready) |=> s_bvalid);

    // R10: read data held stable until accepted
    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata)));

    // R10: read data upper bits are always zero
    a_r10_rdata_upper: assert property (@(posedge clk) disable iff (!rst_n)
        s_rvalid |-> (s_rdata[DATA_W-1:2] == '0));

endmodule

// File: rtl/intx_cmd_engine.sv
// Module: command register, virtual-wire level and message request port.
// Launches a request from an accepted command when interrupts are enabled,
// nothing is outstanding and the command would change the wire level;
// holds the request until msg_ack, then clears it and updates the level.
// Assumes: msg_ack is a pulse from the generator; ack without request is stray.
module intx_cmd_engine
    import intx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  intx_cmd_e        wr_code,
    input  logic             cfg_intx_disable,
    input  logic             cfg_msi_en,
    input  logic [PIN_W-1:0] cfg_pin,
    input  logic             msg_ack,
    output logic [1:0]       cmd_bits,
    output logic             wire_level,
    output logic             msg_valid,
    output logic             msg_assert,
    output logic [PIN_W-1:0] msg_pin
);

    logic [1:0]       cmd_q;
    logic             level_q;
    logic [PIN_W-1:0] pin_q;
    logic             gated;
    logic             idle;
    logic             is_cmd;
    logic             redundant;
    logic             launch;
    logic             done;

    // Decide whether an incoming write becomes a request
    always_comb begin
        gated     = cfg_intx_disable | cfg_msi_en;
        idle      = (cmd_q == CMD_NONE);
        is_cmd    = (wr_code == CMD_ASSERT) || (wr_code == CMD_DEASSERT);
        redundant = ((wr_code == CMD_ASSERT) && level_q) ||
                    ((wr_code == CMD_DEASSERT) && !level_q);
        launch    = wr_en && idle && !gated && is_cmd && !redundant;
        done      = !idle && msg_ack;
    end

    // Command bits, pin select and wire level state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= CMD_NONE;
            level_q <= 1'b0;
            pin_q   <= '0;
        end else if (done) begin
            cmd_q   <= CMD_NONE;
            level_q <= cmd_q[0];
        end else if (launch) begin
            cmd_q   <= wr_code;
            pin_q   <= cfg_pin;
        end
    end

    // Drive request port and status from state
    always_comb begin
        cmd_bits   = cmd_q;
        wire_level = level_q;
        msg_valid  = !idle;
        msg_assert = cmd_q[0];
        msg_pin    = pin_q;
    end

    // R7: never more than one command bit set
    a_r7_single_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_bits));

    // R4: request fields hold until acknowledged
    a_r4_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ack) |=> (msg_valid && $stable(msg_assert) && $stable(msg_pin)));

    // R5: acknowledge ends the request and sets the level to the message type
    a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_ack) |=> (!msg_valid && (wire_level == $past(msg_assert))));

    // R6: gated write raises no request
    a_r6_gated_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (!msg_valid && wr_en && (cfg_intx_disable || cfg_msi_en)) |=> !msg_valid);

    // R7: a write while pending leaves the command unchanged
    a_r7_pending_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && wr_en && !msg_ack) |=> (cmd_bits == $past(cmd_bits)));

    // R9: a new request always changes the wire level
    a_r9_level_change: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> (msg_assert != wire_level));

    // R11: stray acknowledge leaves the level alone
    a_r11_stray_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (!msg_valid && msg_ack && !wr_en) |=> ($stable(wire_level) && !msg_valid));

endmodule

// File: rtl/intx_msg_ctrl.sv
// Module: top of the legacy INTx message request controller.
// Joins the AXI4-Lite responder to the command engine; exposes the
// request/acknowledge port toward the virtual-wire message generator.
// Assumes: configuration inputs are quasi-static and synchronous to clk.
module intx_msg_ctrl
    import intx_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32,
    parameter logic [ADDR_W-1:0] CTRL_OFFSET = ADDR_W'(16)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [DATA_W-1:0] s_wdata,
    input  logic [DATA_W/8-1:0] s_wstrb,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic [1:0]        s_bresp,
    output logic              s_bvalid,
    input  logic              s_bready,
    input  logic [ADDR_W-1:0] s_araddr,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [DATA_W-1:0] s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rvalid,
    input  logic              s_rready,
    input  logic              cfg_intx_disable,
    input  logic              cfg_msi_en,
    input  logic [1:0]        cfg_intx_pin,
    output logic              msg_valid,
    output logic              msg_assert,
    output logic [1:0]        msg_pin,
    input  logic              msg_ack,
    output logic              intx_level
);

    logic      wr_en;
    intx_cmd_e wr_code;
    logic [1:0] cmd_bits;

    intx_axil_port #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .CTRL_OFFSET (CTRL_OFFSET)
    ) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_awaddr  (s_awaddr),
        .s_awvalid (s_awvalid),
        .s_awready (s_awready),
        .s_wdata   (s_wdata),
        .s_wstrb   (s_wstrb),
        .s_wvalid  (s_wvalid),
        .s_wready  (s_wready),
        .s_bresp   (s_bresp),
        .s_bvalid  (s_bvalid),
        .s_bready  (s_bready),
        .s_araddr  (s_araddr),
        .s_arvalid (s_arvalid),
        .s_arready (s_arready),
        .s_rdata   (s_rdata),
        .s_rresp   (s_rresp),
        .s_rvalid  (s_rvalid),
        .s_rready  (s_rready),
        .cmd_bits  (cmd_bits),
        .wr_en     (wr_en),
        .wr_code   (wr_code)
    );

    intx_cmd_engine u_engine (
        .clk              (clk),
        .rst_n            (rst_n),
        .wr_en            (wr_en),
        .wr_code          (wr_code),
        .cfg_intx_disable (cfg_intx_disable),
        .cfg_msi_en       (cfg_msi_en),
        .cfg_pin          (cfg_intx_pin),
        .msg_ack          (msg_ack),
        .cmd_bits         (cmd_bits),
        .wire_level       (intx_level),
        .msg_valid        (msg_valid),
        .msg_assert       (msg_assert),
        .msg_pin          (msg_pin)
    );

    // R1: nothing is requested in the cycle after reset
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!msg_valid && !intx_level && !s_bvalid && !s_rvalid));

endmodule

// File: tb/intx_msg_ctrl_test.sv
// Bench: directed corner cases plus seeded random traffic against a model.
module intx_msg_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam logic [7:0] CTRL = 8'h10;
    localparam int WATCHDOG = 100000;

    logic clk = 1'b0;
    logic rst_n;
    logic [ADDR_W-1:0] s_awaddr, s_araddr;
    logic s_awvalid, s_awready, s_wvalid, s_wready;
    logic [DATA_W-1:0] s_wdata, s_rdata;
    logic [3:0] s_wstrb;
    logic [1:0] s_bresp, s_rresp;
    logic s_bvalid, s_bready, s_arvalid, s_arready, s_rvalid, s_rready;
    logic cfg_intx_disable, cfg_msi_en;
    logic [1:0] cfg_intx_pin;
    logic msg_valid, msg_assert, msg_ack, intx_level;
    logic [1:0] msg_pin;

    int checks = 0;
    int failures = 0;

    // model state
    logic [1:0] exp_cmd = 2'b00;
    logic       exp_level = 1'b0;
    logic [1:0] exp_pin = 2'b00;

    always #(CLK_PERIOD/2) clk = ~clk;

    intx_msg_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_OFFSET(CTRL)) uut (
        .clk(clk), .rst_n(rst_n),
        .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
        .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
        .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
        .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
        .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
        .cfg_intx_disable(cfg_intx_disable), .cfg_msi_en(cfg_msi_en),
        .cfg_intx_pin(cfg_intx_pin),
        .msg_valid(msg_valid), .msg_assert(msg_assert), .msg_pin(msg_pin),
        .msg_ack(msg_ack), .intx_level(intx_level)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // model of a register write per R2, R3, R6, R7, R8, R9
    function automatic void model_write(input logic [7:0] a, input logic [31:0] d,
                                        input logic [3:0] s);
        logic [1:0] code;
        if (a != CTRL || s != 4'hF || exp_cmd != 2'b00) return;
        if (d == 32'h1) code = 2'b01;
        else if (d == 32'h2) code = 2'b10;
        else return;
        if (cfg_intx_disable || cfg_msi_en) return;
        if ((code == 2'b01 && exp_level) || (code == 2'b10 && !exp_level)) return;
        exp_cmd = code;
        exp_pin = cfg_intx_pin;
    endfunction

    task automatic axi_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
        @(negedge clk);
        s_awaddr = a; s_wdata = d; s_wstrb = s; s_awvalid = 1'b1; s_wvalid = 1'b1;
        while (!s_awready) @(negedge clk);
        @(posedge clk);
        model_write(a, d, s);
        @(negedge clk);
        s_awvalid = 1'b0; s_wvalid = 1'b0;
        chk("R10 bvalid", 32'(s_bvalid), 32'd1);
        chk("R10 bresp", 32'(s_bresp), 32'd0);
    endtask

    task automatic axi_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        s_araddr = a; s_arvalid = 1'b1;
        while (!s_arready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        s_arvalid = 1'b0;
        chk("R10 rvalid", 32'(s_rvalid), 32'd1);
        chk("R10 rresp", 32'(s_rresp), 32'd0);
        d = s_rdata;
    endtask

    task automatic pulse_ack();
        @(negedge clk);
        msg_ack = 1'b1;
        @(posedge clk);
        if (exp_cmd != 2'b00) begin
            exp_level = (exp_cmd == 2'b01);
            exp_cmd = 2'b00;
        end
        @(negedge clk);
        msg_ack = 1'b0;
    endtask

    task automatic check_port(input string req);
        chk({req, " msg_valid"}, 32'(msg_valid), 32'(exp_cmd != 2'b00));
        if (exp_cmd != 2'b00) begin
            chk({req, " msg_assert"}, 32'(msg_assert), 32'(exp_cmd == 2'b01));
            chk({req, " msg_pin"}, 32'(msg_pin), 32'(exp_pin));
        end
        chk({req, " intx_level"}, 32'(intx_level), 32'(exp_level));
    endtask

    task automatic check_reg(input string req);
        logic [31:0] d;
        axi_read(CTRL, d);
        chk({req, " readback"}, d, {30'd0, exp_cmd});
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        s_awaddr = '0; s_awvalid = 0; s_wdata = '0; s_wstrb = '0; s_wvalid = 0;
        s_bready = 1'b1; s_araddr = '0; s_arvalid = 0; s_rready = 1'b1;
        cfg_intx_disable = 0; cfg_msi_en = 0; cfg_intx_pin = 2'd2; msg_ack = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 msg_valid", 32'(msg_valid), 0);
        chk("R1 intx_level", 32'(intx_level), 0);
        chk("R1 bvalid", 32'(s_bvalid), 0);
        chk("R1 rvalid", 32'(s_rvalid), 0);
        rst_n = 1'b1;
        check_reg("R1");

        // R11: stray ack while idle
        pulse_ack();
        check_port("R11");
        check_reg("R11");

        // R9: deassert while deasserted completes at once
        axi_write(CTRL, 32'h2, 4'hF);
        check_port("R9");
        check_reg("R9");

        // R2: assert on INTC
        axi_write(CTRL, 32'h1, 4'hF);
        chk("R2 msg_valid", 32'(msg_valid), 1);
        chk("R2 msg_assert", 32'(msg_assert), 1);
        chk("R2 msg_pin", 32'(msg_pin), 2);
        check_reg("R2");

        // R7: writes while pending ignored; R4 fields hold
        cfg_intx_pin = 2'd1;
        axi_write(CTRL, 32'h2, 4'hF);
        repeat (3) @(negedge clk);
        check_port("R4");
        check_reg("R7");

        // R5: ack clears, level asserted
        pulse_ack();
        chk("R5 msg_valid", 32'(msg_valid), 0);
        chk("R5 intx_level", 32'(intx_level), 1);
        check_reg("R5");

        // R9: assert while asserted
        axi_write(CTRL, 32'h1, 4'hF);
        check_port("R9");
        check_reg("R9");

        // R8: invalid value, partial strobe, other address
        axi_write(CTRL, 32'h3, 4'hF);
        check_port("R8");
        axi_write(CTRL, 32'h102, 4'hF);
        check_port("R8");
        axi_write(CTRL, 32'h2, 4'h1);
        check_port("R8");
        axi_write(CTRL + 8'h4, 32'h2, 4'hF);
        check_port("R8");
        axi_read(CTRL + 8'h4, rd);
        chk("R10 other addr read", rd, 0);

        // R6: gated by interrupt disable, then by MSI
        cfg_intx_disable = 1'b1;
        axi_write(CTRL, 32'h2, 4'hF);
        check_port("R6");
        check_reg("R6");
        cfg_intx_disable = 1'b0; cfg_msi_en = 1'b1;
        axi_write(CTRL, 32'h2, 4'hF);
        check_port("R6");
        cfg_msi_en = 1'b0;

        // R3: deassert on INTA
        cfg_intx_pin = 2'd0;
        axi_write(CTRL, 32'h2, 4'hF);
        chk("R3 msg_assert", 32'(msg_assert), 0);
        chk("R3 msg_valid", 32'(msg_valid), 1);
        check_reg("R3");
        pulse_ack();
        check_port("R5");

        // random traffic
        for (int i = 0; i < 600; i++) begin
            int op;
            op = int'($urandom % 10);
            if (op < 4) begin
                logic [31:0] d;
                logic [7:0] a;
                logic [3:0] s;
                case ($urandom % 6)
                    0, 1: d = 32'h1;
                    2, 3: d = 32'h2;
                    4: d = 32'h3;
                    default: d = $urandom;
                endcase
                a = ($urandom % 8 == 0) ? CTRL + 8'h8 : CTRL;
                s = ($urandom % 8 == 0) ? 4'h7 : 4'hF;
                axi_write(a, d, s);
                check_port("R7 random write");
            end else if (op < 6) begin
                pulse_ack();
                check_port("R5 random ack");
            end else if (op == 6) begin
                check_reg("R10 random read");
            end else if (op == 7) begin
                @(negedge clk);
                cfg_intx_disable = ($urandom % 4 == 0);
                cfg_msi_en = ($urandom % 4 == 0);
                cfg_intx_pin = 2'($urandom);
            end else begin
                repeat (1 + $urandom % 3) @(negedge clk);
                check_port("R4 random idle");
            end
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule